// File: doc/BRIEF.md
# DMA Completion Interrupt Controller

This block converts transfer-completion events from a DMA engine into a prioritized interrupt request toward the CPU. Each completion pulse comes with four qualifiers: whether the transfer counter reached zero, the descriptor's interrupt-enable bit, whether descriptor chaining is active, and whether the finishing descriptor is the final one in its chain. Only a qualifying completion latches a sticky cause flag.

Software uses a small synchronous register port to work with four registers. It can clear the flag, enable or mask the request, program a 3-bit priority level, and relocate the trap table base. The masked request is compared against a vector of competing pending requests and against the CPU's global enable and current level. This produces a forwarded request and an accept indication. The trap vector address is always the table base plus a fixed offset.

Top module: `dma_done_irq`

## Requirements
- R1: With chaining off (`link_mode`=0), a `done` pulse sets the cause flag at the next clock edge when `cnt_zero`=1 and `desc_ie`=1.
- R2: With chaining on (`link_mode`=1), a `done` pulse sets the flag only when `chain_last`=1, `cnt_zero`=1 and `desc_ie`=1. Intermediate descriptors (`chain_last`=0) never set it.
- R3: A `done` pulse with `cnt_zero`=0 or `desc_ie`=0 leaves the flag unchanged.
- R4: Writing data bit 0 = 1 to address 0 clears the flag. If a set event occurs in the same cycle, the flag is set.
- R5: `irq_req` is 1 exactly when the flag is 1 and the enable bit is 1. The enable bit is data bit 0 at address 1. Clearing the enable bit masks the request while the flag stays readable as 1 at address 0, bit 0.
- R6: The priority level is a 3-bit register at address 2, bits [2:0], holding values 0 to 7. It reads back as written, with the upper bits zero.
- R7: `irq_fwd` is 1 when `irq_req` is 1 and no source with `rival_pend`[i]=1 has a level `rival_lvl`[3i+2:3i] strictly greater than the priority. An equal level does not block.
- R8: `irq_take` is 1 exactly when `irq_fwd`=1, `cpu_ie`=1 and `cpu_lvl` is strictly less than the priority.
- R9: The table base is at address 3 (24 bits) and resets to 0xC00000. `trap_vec` always equals the base plus 0x68, so it resets to 0xC00068 and moves with every base write.
- R10: After reset, the flag, enable and priority read as zero and all three request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| done | input | 1 | One-cycle DMA completion pulse |
| cnt_zero | input | 1 | Transfer counter is zero at this completion |
| desc_ie | input | 1 | Descriptor interrupt-enable bit |
| link_mode | input | 1 | Descriptor chaining active |
| chain_last | input | 1 | Completing descriptor is last in chain |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 flag, 1 enable, 2 priority, 3 base |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for `bus_addr` (combinational) |
| rival_pend | input | NSRC | Competing request pending per source |
| rival_lvl | input | 3*NSRC | Competing request levels, 3 bits per source |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_lvl | input | 3 | CPU current interrupt level |
| irq_req | output | 1 | Flag and enable both set |
| irq_fwd | output | 1 | Request survives level arbitration |
| irq_take | output | 1 | CPU accepts the request |
| trap_vec | output | 24 | Trap vector address |

## Verification
On every cycle, the assertions check the following:
- A qualifying completion is followed by a set flag.
- A lone clear drops the flag.
- A completion from an intermediate chained descriptor never changes the flag.
- The forwarded and accepted outputs never appear without the lower-level conditions that permit them.

The exact arbitration outcomes can only be shown by the bench's scenarios. These include the tie in favour of this block, a blocking rival that is not pending, and the strict comparison against the CPU level. The same holds for the set-over-clear collision, the masking that preserves the flag, and the relocated vector value.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int LVL_W = 3;
  localparam int AW    = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef enum logic [AW-1:0] {
    SEL_FLAG = 2'd0,
    SEL_EN   = 2'd1,
    SEL_PRI  = 2'd2,
    SEL_BASE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dmairq_evt.sv
module dmairq_evt (
  input  logic done,
  input  logic cnt_zero,
  input  logic desc_ie,
  input  logic link_mode,
  input  logic chain_last,
  output logic set_ev
);
  logic qualified;
  logic chain_ok;

  always_comb begin
    qualified = done && cnt_zero && desc_ie;
    // unchained: every descriptor counts; chained: only the tail
    chain_ok  = !link_mode || chain_last;
    set_ev    = qualified && chain_ok;
  end
endmodule

// File: rtl/dmairq_regs.sv
module dmairq_regs
  import dmairq_pkg::*;
#(
  parameter int          DW       = 24,
  parameter logic [DW-1:0] BASE_RST = 24'hC00000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_ev,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          flag,
  output logic          en,
  output lvl_t          pri,
  output logic [DW-1:0] base,
  output logic [DW-1:0] rdata
);
  logic          flag_d, en_d;
  lvl_t          pri_d;
  logic [DW-1:0] base_d;
  logic          clr_hit, en_wr, pri_wr, base_wr;

  always_comb begin
    clr_hit = we && (reg_sel_e'(addr) == SEL_FLAG) && wdata[0];
    en_wr   = we && (reg_sel_e'(addr) == SEL_EN);
    pri_wr  = we && (reg_sel_e'(addr) == SEL_PRI);
    base_wr = we && (reg_sel_e'(addr) == SEL_BASE);
    // set has priority over a simultaneous write-1-to-clear
    flag_d  = set_ev ? 1'b1 : (clr_hit ? 1'b0 : flag);
    en_d    = en_wr   ? wdata[0]         : en;
    pri_d   = pri_wr  ? wdata[LVL_W-1:0] : pri;
    base_d  = base_wr ? wdata            : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      en   <= 1'b0;
      pri  <= '0;
      base <= BASE_RST;
    end else begin
      flag <= flag_d;
      en   <= en_d;
      pri  <= pri_d;
      base <= base_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (reg_sel_e'(addr))
      SEL_FLAG: rdata[0]         = flag;
      SEL_EN:   rdata[0]         = en;
      SEL_PRI:  rdata[LVL_W-1:0] = pri;
      SEL_BASE: rdata            = base;
      default:  rdata            = '0;
    endcase
  end

  a_r1_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag);
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !set_ev) |=> !flag);
  a_r3_hold_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ev && !we) |=> $stable(flag));
endmodule

// File: rtl/dmairq_arb.sv
module dmairq_arb
  import dmairq_pkg::*;
#(
  parameter int            NSRC    = 4,
  parameter int            DW      = 24,
  parameter logic [DW-1:0] VEC_OFF = 24'h000068
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flag,
  input  logic                  en,
  input  lvl_t                  pri,
  input  logic [DW-1:0]         base,
  input  logic [NSRC-1:0]       rival_pend,
  input  logic [NSRC*LVL_W-1:0] rival_lvl,
  input  logic                  cpu_ie,
  input  lvl_t                  cpu_lvl,
  output logic                  irq_req,
  output logic                  irq_fwd,
  output logic                  irq_take,
  output logic [DW-1:0]         trap_vec
);
  logic [NSRC-1:0] beats;

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    // strict compare: an equal level never outranks this request
    assign beats[i] = rival_pend[i] && (rival_lvl[i*LVL_W +: LVL_W] > pri);
  end

  always_comb begin
    irq_req  = flag && en;
    irq_fwd  = irq_req && (beats == '0);
    irq_take = irq_fwd && cpu_ie && (cpu_lvl < pri);
    trap_vec = base + VEC_OFF;
  end

  a_r5_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq_req);
  a_r7_fwd_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fwd |-> (irq_req && flag));
  a_r8_take_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (cpu_ie && (cpu_lvl < pri) && irq_fwd));
endmodule

// File: rtl/dma_done_irq.sv
module dma_done_irq
  import dmairq_pkg::*;
#(
  parameter int            NSRC     = 4,
  parameter int            DW       = 24,
  parameter logic [DW-1:0] BASE_RST = 24'hC00000,
  parameter logic [DW-1:0] VEC_OFF  = 24'h000068
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  done,
  input  logic                  cnt_zero,
  input  logic                  desc_ie,
  input  logic                  link_mode,
  input  logic                  chain_last,
  input  logic                  bus_we,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic [NSRC-1:0]       rival_pend,
  input  logic [NSRC*LVL_W-1:0] rival_lvl,
  input  logic                  cpu_ie,
  input  logic [LVL_W-1:0]      cpu_lvl,
  output logic                  irq_req,
  output logic                  irq_fwd,
  output logic                  irq_take,
  output logic [DW-1:0]         trap_vec
);
  logic          rst_s1, rst_sn;
  logic          set_ev, flag, en;
  lvl_t          pri;
  logic [DW-1:0] base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  dmairq_evt u_evt (
    .done(done), .cnt_zero(cnt_zero), .desc_ie(desc_ie),
    .link_mode(link_mode), .chain_last(chain_last), .set_ev(set_ev)
  );

  dmairq_regs #(.DW(DW), .BASE_RST(BASE_RST)) u_regs (
    .clk(clk), .rst_n(rst_sn), .set_ev(set_ev), .we(bus_we),
    .addr(bus_addr), .wdata(bus_wdata), .flag(flag), .en(en),
    .pri(pri), .base(base), .rdata(bus_rdata)
  );

  dmairq_arb #(.NSRC(NSRC), .DW(DW), .VEC_OFF(VEC_OFF)) u_arb (
    .clk(clk), .rst_n(rst_sn), .flag(flag), .en(en), .pri(pri),
    .base(base), .rival_pend(rival_pend), .rival_lvl(rival_lvl),
    .cpu_ie(cpu_ie), .cpu_lvl(cpu_lvl), .irq_req(irq_req),
    .irq_fwd(irq_fwd), .irq_take(irq_take), .trap_vec(trap_vec)
  );

  // R2: an intermediate chained descriptor must not disturb the flag
  a_r2_mid_chain: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && link_mode && !chain_last && !bus_we) |=> $stable(irq_req));
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_sn |-> (!irq_req && !irq_fwd && !irq_take));
endmodule

// File: tb/sim_dma_done_irq.sv
module sim_dma_done_irq;
  localparam int NSRC = 4;
  localparam int DW   = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done = 0, cnt_zero = 0, desc_ie = 0, link_mode = 0, chain_last = 0;
  logic bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0;
  logic [DW-1:0] bus_rdata;
  logic [NSRC-1:0] rival_pend = 0;
  logic [NSRC*3-1:0] rival_lvl = 0;
  logic cpu_ie = 0;
  logic [2:0] cpu_lvl = 0;
  logic irq_req, irq_fwd, irq_take;
  logic [DW-1:0] trap_vec;

  always #4 clk = ~clk;

  dma_done_irq #(.NSRC(NSRC), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .done(done), .cnt_zero(cnt_zero),
    .desc_ie(desc_ie), .link_mode(link_mode), .chain_last(chain_last),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rival_pend(rival_pend), .rival_lvl(rival_lvl),
    .cpu_ie(cpu_ie), .cpu_lvl(cpu_lvl), .irq_req(irq_req),
    .irq_fwd(irq_fwd), .irq_take(irq_take), .trap_vec(trap_vec)
  );

  typedef struct packed {
    logic          req;
    logic          fwd;
    logic          take;
    logic [DW-1:0] vec;
    logic [DW-1:0] rd;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];
  int nchk = 0, nfail = 0;
  logic finished = 0;

  // reference model state
  logic m_flag = 0, m_en = 0;
  logic [2:0] m_pri = 0;
  logic [DW-1:0] m_base = 24'hC00000;

  task automatic tick(input string tag);
    logic sev, clr, blocked;
    exp_t e;
    @(posedge clk);
    sev = done && cnt_zero && desc_ie && (!link_mode || chain_last);
    clr = bus_we && bus_addr == 2'd0 && bus_wdata[0];
    m_flag = sev ? 1'b1 : (clr ? 1'b0 : m_flag);
    if (bus_we && bus_addr == 2'd1) m_en = bus_wdata[0];
    if (bus_we && bus_addr == 2'd2) m_pri = bus_wdata[2:0];
    if (bus_we && bus_addr == 2'd3) m_base = bus_wdata;
    blocked = 0;
    for (int i = 0; i < NSRC; i++)
      if (rival_pend[i] && rival_lvl[i*3 +: 3] > m_pri) blocked = 1;
    e.req  = m_flag && m_en;
    e.fwd  = e.req && !blocked;
    e.take = e.fwd && cpu_ie && (cpu_lvl < m_pri);
    e.vec  = m_base + 24'h68;
    case (bus_addr)
      2'd0: e.rd = {23'd0, m_flag};
      2'd1: e.rd = {23'd0, m_en};
      2'd2: e.rd = {21'd0, m_pri};
      default: e.rd = m_base;
    endcase
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d, input string tag);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    tick(tag);
    bus_we = 0;
  endtask

  task automatic ev(input logic z, input logic ie, input logic lk,
                    input logic last, input string tag);
    done = 1; cnt_zero = z; desc_ie = ie; link_mode = lk; chain_last = last;
    tick(tag);
    done = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    bus_addr = a;
    tick(tag);
  endtask

  // monitor: compare design outputs with queued expectations
  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      exp_t e;
      exp_t got;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      got = '{req: irq_req, fwd: irq_fwd, take: irq_take, vec: trap_vec, rd: bus_rdata};
      nchk++;
      if (got !== e) begin
        nfail++;
        $display("FAIL %s: got req=%0b fwd=%0b take=%0b vec=%06h rd=%06h exp req=%0b fwd=%0b take=%0b vec=%06h rd=%06h",
          t, got.req, got.fwd, got.take, got.vec, got.rd,
          e.req, e.fwd, e.take, e.vec, e.rd);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10 / R9 reset state
    rd(2'd0, "R10 flag reset");
    rd(2'd1, "R10 enable reset");
    rd(2'd2, "R10 priority reset");
    rd(2'd3, "R9 base reset");
    // R6 priority programming and readback
    wr(2'd2, 24'hFFFFF5, "R6 write priority");
    rd(2'd2, "R6 priority readback");
    wr(2'd1, 24'd1, "R5 enable on");
    cpu_ie = 1; cpu_lvl = 3'd2;
    // R3 non-qualifying completions
    bus_addr = 2'd0;
    ev(0, 1, 0, 0, "R3 counter nonzero");
    ev(1, 0, 0, 0, "R3 descriptor ie off");
    // R1 unchained set
    ev(1, 1, 0, 0, "R1 unchained set");
    rd(2'd0, "R8 take with lower cpu level");
    // R4 clear
    wr(2'd0, 24'd1, "R4 write one clears");
    wr(2'd0, 24'd0, "R4 write zero no clear");
    // R2 chained
    bus_addr = 2'd0;
    ev(1, 1, 1, 0, "R2 intermediate link ignored");
    ev(1, 1, 1, 1, "R2 last link sets");
    // R4 collision: clear and set together
    bus_we = 1; bus_addr = 2'd0; bus_wdata = 24'd1;
    done = 1; cnt_zero = 1; desc_ie = 1; link_mode = 0;
    tick("R4 set beats clear");
    bus_we = 0; done = 0;
    // R5 masking keeps flag
    wr(2'd1, 24'd0, "R5 mask request");
    rd(2'd0, "R5 flag kept while masked");
    wr(2'd1, 24'd1, "R5 unmask");
    // R7 arbitration
    rival_pend = 4'b0100; rival_lvl = {3'd0, 3'd5, 3'd0, 3'd0};
    rd(2'd0, "R7 tie favours this block");
    rival_lvl = {3'd0, 3'd6, 3'd0, 3'd0};
    rd(2'd0, "R7 higher rival blocks");
    rival_pend = 4'b1011;
    rd(2'd0, "R7 higher rival not pending");
    rival_pend = 4'b0000;
    // R8 cpu gating
    cpu_lvl = 3'd5;
    rd(2'd0, "R8 equal cpu level refuses");
    cpu_lvl = 3'd4;
    rd(2'd0, "R8 cpu level below accepts");
    cpu_ie = 0;
    rd(2'd0, "R8 global disable refuses");
    // R9 relocation
    wr(2'd3, 24'h123400, "R9 base relocated");
    rd(2'd3, "R9 base readback");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule